// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block turns a fast sample clock into a one-cycle clock-enable pulse that repeats every N input cycles, where N is programmable from 1 to 8. Logic that should run at the divided rate stays on the input clock and qualifies its registers with the pulse. This keeps a single clock domain and avoids a derived clock net.

Several copies of the block, one per device, can be brought into phase by a shared alignment strobe. When an alignment event is accepted, the divider counter returns to zero. Every copy then produces its pulse on the same input cycle, so the converters behind them sample together.

Two configuration bits decide how the strobe is treated. One bit enables alignment at all. The other bit chooses between acting on every strobe and acting only on the first strobe after a configuration write. In the second mode, an "armed" flag shows whether that single permitted event is still pending.

Top module: `clkdiv_sync`

## Requirements
- R1: The input `ratio_m1` holds the divide ratio minus one, so value v gives ratio v+1. For v of 1 or more, `div_en` is high for exactly one input cycle out of every v+1 cycles.
- R2: While `rst` is high (synchronous, active high), the counter is held at zero, the active ratio is loaded from `ratio_m1`, and `armed` is low. With a ratio above 1, `div_en` is low during reset. The first pulse comes v cycles after the release edge.
- R3: A new `ratio_m1` value takes effect only at the next counter wrap or at the next accepted alignment event. The period already in progress finishes at the old ratio.
- R4: `sync_in` is sampled on the clock, and only a low-to-high change counts as an event. A level held high for several cycles is one event. An accepted event forces the counter to zero on the second rising edge after `sync_in` is first sampled high, so the next pulse follows ratio cycles later.
- R5: While `sync_en` is low, `sync_in` has no effect on the pulse phase.
- R6: With `sync_en` high and `one_shot` low, every event is accepted.
- R7: A write (`cfg_wr` high for one cycle) with `one_shot` high sets `armed`. With `sync_en` high, the first event after that write is accepted and clears `armed`. Later events are ignored until the next write.
- R8: A write with `one_shot` low clears `armed`.
- R9: If a write and an accepted event fall in the same cycle, both take effect: the counter resets, and `armed` takes the value of `one_shot`.
- R10: With a ratio of 1 (v = 0), `div_en` is high on every input cycle, including the cycles around an accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_m1 | input | 3 | Divide ratio minus one |
| sync_en | input | 1 | Enables alignment by `sync_in` |
| one_shot | input | 1 | 1: only the first event after a write is accepted; 0: every event is accepted |
| cfg_wr | input | 1 | One-cycle strobe marking a configuration write |
| sync_in | input | 1 | Alignment strobe |
| div_en | output | 1 | Divided clock-enable pulse |
| armed | output | 1 | High while a one-shot event is still pending |

## Verification
Two events can land on the same clock edge.

- **Configuration write and accepted event.** The bench raises `cfg_wr` in the exact cycle in which the detected edge is accepted. It then judges that the counter still resets, by the position of the next pulse, and that `armed` is set again rather than cleared. A second strobe then shows that the re-armed flag is really usable.
- **Counter wrap and ratio change, or alignment reset and ratio change.** The bench changes the ratio in the middle of a period and watches that the old period completes. It also changes the ratio together with a strobe and watches that the new ratio applies from the reset on.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;

   // Treatment of alignment events
   typedef enum logic {
      SYNC_EVERY = 1'b0,   // every detected edge is accepted
      SYNC_FIRST = 1'b1    // only the first edge after a write
   } sync_mode_e;

   function automatic int unsigned ratio_bits(input int unsigned max_ratio);
      return (max_ratio < 2) ? 1 : $clog2(max_ratio);
   endfunction

endpackage

// File: rtl/clkdiv_sync_edge.sv
module clkdiv_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkdiv_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[STAGES-2:0], sync_in};
   end

   assign rise = shreg[STAGES-2] & ~shreg[STAGES-1];

   // R4: a held level yields one event only
   a_r4_single_event: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/clkdiv_sync_arm.sv
module clkdiv_sync_arm
   import clkdiv_sync_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic rise,
   input  logic sync_en,
   input  logic one_shot,
   input  logic cfg_wr,
   output logic accept,
   output logic armed
);
   sync_mode_e mode;
   logic       armed_q;

   assign mode   = sync_mode_e'(one_shot);
   assign accept = rise & sync_en & ((mode == SYNC_EVERY) | armed_q);
   assign armed  = armed_q;

   always_ff @(posedge clk) begin
      if (rst)           armed_q <= 1'b0;
      else if (cfg_wr)   armed_q <= (mode == SYNC_FIRST);
      else if (accept)   armed_q <= 1'b0;
   end

   // R7 / R8 / R9: a write always decides the flag
   a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
      cfg_wr |=> (armed == $past(one_shot)));

   // R7: an accepted one-shot event disarms
   a_r7_disarm: assert property (@(posedge clk) disable iff (rst)
      (accept && one_shot && !cfg_wr) |=> !armed);

   // R5: nothing is accepted while disabled
   a_r5_disabled: assert property (@(posedge clk) disable iff (rst)
      !sync_en |-> !accept);

endmodule

// File: rtl/clkdiv_sync_count.sv
module clkdiv_sync_count #(
   parameter int unsigned RW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [RW-1:0] ratio_m1,
   input  logic          accept,
   output logic          div_en
);
   logic [RW-1:0] cnt;
   logic [RW-1:0] act_m1;
   logic          wrap;

   assign wrap   = (cnt == act_m1);
   assign div_en = wrap;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         act_m1 <= ratio_m1;
      end else if (accept || wrap) begin
         cnt    <= '0;
         act_m1 <= ratio_m1;
      end else begin
         cnt    <= cnt + 1'b1;
      end
   end

   // R1: the counter never passes its terminal value
   a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
      cnt <= act_m1);

   // R4: an accepted event clears the phase and loads the ratio
   a_r4_sync_reset: assert property (@(posedge clk) disable iff (rst)
      accept |=> (cnt == '0) && (act_m1 == $past(ratio_m1)));

   // R3: the ratio stays frozen inside a period
   a_r3_ratio_hold: assert property (@(posedge clk) disable iff (rst)
      (!accept && !wrap) |=> $stable(act_m1) && (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync
   import clkdiv_sync_pkg::*;
#(
   parameter int unsigned MAX_RATIO   = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned RW         = ratio_bits(MAX_RATIO)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [RW-1:0] ratio_m1,
   input  logic          sync_en,
   input  logic          one_shot,
   input  logic          cfg_wr,
   input  logic          sync_in,
   output logic          div_en,
   output logic          armed
);
   generate
      if ((MAX_RATIO < 2) || ((1 << RW) != MAX_RATIO)) begin : g_bad_ratio
         $error("clkdiv_sync: MAX_RATIO must be a power of two, at least 2");
      end
   endgenerate

   logic rise;
   logic accept;

   clkdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .sync_in (sync_in),
      .rise    (rise)
   );

   clkdiv_sync_arm u_arm (
      .clk      (clk),
      .rst      (rst),
      .rise     (rise),
      .sync_en  (sync_en),
      .one_shot (one_shot),
      .cfg_wr   (cfg_wr),
      .accept   (accept),
      .armed    (armed)
   );

   clkdiv_sync_count #(.RW(RW)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .ratio_m1 (ratio_m1),
      .accept   (accept),
      .div_en   (div_en)
   );

   // R10: ratio one keeps the enable high continuously
   a_r10_ratio_one: assert property (@(posedge clk) disable iff (rst)
      (ratio_m1 == '0 && $past(ratio_m1) == '0 && div_en) |=> div_en);

endmodule

// File: tb/sim_clkdiv_sync.sv
module sim_clkdiv_sync;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] ratio_m1;
   logic       sync_en, one_shot, cfg_wr, sync_in;
   logic       div_en, armed;
   int         n_chk  = 0;
   int         n_fail = 0;
   bit         done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkdiv_sync u0 (
      .clk(clk), .rst(rst), .ratio_m1(ratio_m1), .sync_en(sync_en),
      .one_shot(one_shot), .cfg_wr(cfg_wr), .sync_in(sync_in),
      .div_en(div_en), .armed(armed)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // Wait until a pulse is visible at a falling edge
   task automatic align();
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (div_en) return;
      end
   endtask

   // Falling edges from now until the next pulse
   task automatic interval(output int idx);
      idx = -1;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (div_en) begin idx = i; return; end
      end
   endtask

   // Raise sync_in for three cycles, optionally write in the accept cycle
   task automatic sync_measure(input bit wr_at1, output int idx);
      idx = -1;
      sync_in = 1'b1;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (i == 1 && wr_at1) cfg_wr = 1'b1;
         if (i == 2) cfg_wr = 1'b0;
         if (i == 3) sync_in = 1'b0;
         if (div_en && i >= 2) begin idx = i; break; end
      end
      sync_in = 1'b0;
      cfg_wr  = 1'b0;
   endtask

   task automatic cfg_write(input bit os);
      one_shot = os;
      cfg_wr   = 1'b1;
      @(negedge clk);
      cfg_wr   = 1'b0;
   endtask

   task automatic t_reset();
      int idx;
      rst = 1'b1; ratio_m1 = 3'd3;
      repeat (4) @(negedge clk);
      chk("R2 div_en in reset", div_en, 0);
      chk("R2 armed in reset", armed, 0);
      rst = 1'b0;
      interval(idx);
      chk("R2 first pulse after release", idx, 3);
   endtask

   task automatic t_ratios();
      int idx;
      for (int v = 1; v < 8; v++) begin
         ratio_m1 = 3'(v);
         align(); align();
         interval(idx);
         chk($sformatf("R1 period for ratio %0d", v + 1), idx, v + 1);
      end
   endtask

   task automatic t_ratio_change();
      int idx;
      ratio_m1 = 3'd7;
      align(); align();
      repeat (2) @(negedge clk);
      ratio_m1 = 3'd1;
      interval(idx);
      chk("R3 old period completes", idx, 6);
      interval(idx);
      chk("R3 new period after wrap", idx, 2);
      ratio_m1 = 3'd7;
      align(); align();
      @(negedge clk);
      sync_en = 1'b1; ratio_m1 = 3'd2;
      sync_measure(1'b0, idx);
      chk("R3 ratio loaded by sync reset", idx, 4);
   endtask

   task automatic t_continuous();
      int idx;
      ratio_m1 = 3'd7; sync_en = 1'b1;
      cfg_write(1'b0);
      align(); align();
      repeat (3) @(negedge clk);
      sync_measure(1'b0, idx);
      chk("R4 phase after sync", idx, 9);
      interval(idx);
      chk("R4 held level counts once", idx, 8);
      repeat (3) @(negedge clk);
      sync_measure(1'b0, idx);
      chk("R6 second sync accepted", idx, 9);
   endtask

   task automatic t_disabled();
      int idx;
      sync_en = 1'b0;
      align();
      repeat (3) @(negedge clk);
      sync_measure(1'b0, idx);
      chk("R5 sync ignored when disabled", idx, 5);
      sync_en = 1'b1;
   endtask

   task automatic t_oneshot();
      int idx;
      cfg_write(1'b1);
      chk("R7 write arms", armed, 1);
      align();
      repeat (3) @(negedge clk);
      sync_measure(1'b0, idx);
      chk("R7 first sync accepted", idx, 9);
      chk("R7 accept disarms", armed, 0);
      repeat (3) @(negedge clk);
      sync_measure(1'b0, idx);
      chk("R7 later sync ignored", idx, 5);
      cfg_write(1'b1);
      chk("R8 rearmed before clear", armed, 1);
      cfg_write(1'b0);
      chk("R8 continuous write clears", armed, 0);
   endtask

   task automatic t_collision();
      int idx;
      cfg_write(1'b1);
      align();
      repeat (3) @(negedge clk);
      sync_measure(1'b1, idx);
      chk("R9 counter reset with write", idx, 9);
      chk("R9 write keeps armed", armed, 1);
      repeat (3) @(negedge clk);
      sync_measure(1'b0, idx);
      chk("R9 rearmed sync accepted", idx, 9);
      chk("R9 disarmed afterwards", armed, 0);
   endtask

   task automatic t_ratio_one();
      int hi = 0;
      cfg_write(1'b0);
      ratio_m1 = 3'd0;
      align(); align();
      sync_in = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 2) sync_in = 1'b0;
         hi += div_en;
      end
      chk("R10 ratio one always high", hi, 8);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; ratio_m1 = '0; sync_en = 1'b0; one_shot = 1'b0;
      cfg_wr = 1'b0; sync_in = 1'b0;
      @(negedge clk);
      t_reset();
      t_ratios();
      t_ratio_change();
      t_continuous();
      t_disabled();
      t_oneshot();
      t_collision();
      t_ratio_one();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule